// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block builds the status word and the ready/busy indication of a flash memory model while an automatic program or erase runs in the background. The operation sequencer tells it when an operation starts (with its kind, the most significant bit of the data being written and the target sector), when it completes, when its internal pulse budget is exhausted, and when the host asks to suspend or resume an erase. The host side presents read strobes together with the sector index of the read address and the array data for that address. Each read returns either a status word or plain array data, one cycle after the strobe.

A status word carries four live fields. The polling bit (bit 7) shows the complement of the written data bit 7 during a program. It reads 0 during an erase and 1 while the erase is suspended. The primary toggle bit (bit 6) changes on every status read of an active operation. The timeout bit (bit 5) is raised when the pulse budget runs out. The secondary toggle bit (bit 2) changes on each status read of an erase, including reads of the suspended sector. The busy flag models an open-drain line: it pulls low while work is pending and releases while the block is idle or an erase is suspended. A suspend request always reaches the suspended state after a fixed, bounded number of cycles.

Top module: `emb_status_gen`

## Requirements
- R1: After reset the block is idle: `ry_pull_low`=0, `rd_valid`=0, `rd_data`=0. A read while idle returns `arr_data` as sampled with the strobe.
- R2: While a program runs, bit 7 of every status read equals the inverse of `prog_msb` captured at the start.
- R3: While an erase runs (including the cycles waiting to suspend), bit 7 of a status read is 0. After completion, reads return array data.
- R4: Bit 6 of a status read inverts between one status read and the next while an operation is active. It holds across idle cycles and across reads that return array data, and it is left unchanged by a completion.
- R5: `op_fail` sets bit 5 of the status word. The block then stays busy and keeps returning status, ignoring `op_done`, until `reset_cmd`. After `reset_cmd` it is idle.
- R6: `ry_pull_low` is 1 during a program, an erase, the wait for suspend and the timeout state. It is 0 when idle or suspended.
- R7: A `susp_req` during an erase reaches the suspended state exactly SUSP_LAT clock edges after the edge that samples it. A `susp_req` during a program has no effect.
- R8: While suspended, reads whose sector equals the erase sector return status with bit 7=1, bit 6 unchanged and bit 5=0. Reads of any other sector return array data. `resume_req` returns the block to an active erase.
- R9: Bit 2 inverts on each status read that belongs to an erase, and holds during a program.
- R10: `op_start` is ignored unless the block is idle. The captured kind and data bit stay as they were.
- R11: A read strobed in the same cycle as `op_done` still returns the status of the running operation. The next read returns array data, and bits 7 and 5 switch at that single edge.
- R12: `rd_valid` is 1 exactly in the cycle after each strobe. In a status word, bits 4, 3, 1, 0 (and any above 7) are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | Sequencer: operation begins |
| op_erase | input | 1 | Kind of starting operation: 1 erase, 0 program |
| prog_msb | input | 1 | Bit 7 of the data being programmed |
| op_sect | input | AW-SECT_LSB | Sector of the starting operation |
| op_done | input | 1 | Sequencer: operation completed |
| op_fail | input | 1 | Sequencer: pulse count limit exceeded |
| susp_req | input | 1 | Erase suspend request |
| resume_req | input | 1 | Erase resume request |
| reset_cmd | input | 1 | Reset command, clears a timeout |
| rd_strobe | input | 1 | Read access this cycle |
| rd_sect | input | AW-SECT_LSB | Sector index of the read address |
| arr_data | input | DW | Array data for the read address |
| rd_data | output | DW | Read result, registered |
| rd_valid | output | 1 | `rd_data` holds a new result |
| ry_pull_low | output | 1 | 1 pulls the ready/busy line low (busy) |

## Verification
On every cycle, the embedded assertions check the following:
- The polling bit against the captured data during a program.
- Array pass-through while idle.
- Stickiness of the timeout state.
- The bound on the suspend wait.
- Release of the busy line while suspended.
- The one-cycle read latency.
- Per-lane toggle behaviour.

Only the bench scenarios show the rest:
- The toggle sequence seen across successive reads.
- The sector selectivity of suspended reads over all sector pairs.
- The exact suspend latency.
- The atomic switch at completion when a read coincides with `op_done`.
- That a second start or a program-time suspend leaves results unchanged.

// File: rtl/est_pkg.sv
// Shared types for the embedded operation status generator.
// Assumes the status word is at least 8 bits wide.
package est_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PROG  = 3'd1,
        ST_ERASE = 3'd2,
        ST_SWAIT = 3'd3,
        ST_SUSP  = 3'd4,
        ST_TOUT  = 3'd5
    } est_state_e;

    localparam int POLL_BIT = 7;
    localparam int TOG_BIT  = 6;
    localparam int TOUT_BIT = 5;
    localparam int ALT_BIT  = 2;

    // toggle lane indices
    localparam int LANE_PRI = 0;
    localparam int LANE_ALT = 1;
    localparam int LANES    = 2;
endpackage

// File: rtl/est_seq.sv
// Operation tracker: follows the sequencer events and holds the operation
// state, the captured kind, data bit 7 and sector, and the suspend wait counter.
// Assumes SUSP_LAT >= 2 and one-cycle event pulses from the sequencer.
module est_seq
    import est_pkg::*;
#(
    parameter int SW       = 4,
    parameter int SUSP_LAT = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_start,
    input  logic          op_erase,
    input  logic          prog_msb,
    input  logic [SW-1:0] op_sect,
    input  logic          op_done,
    input  logic          op_fail,
    input  logic          susp_req,
    input  logic          resume_req,
    input  logic          reset_cmd,
    output est_state_e    state,
    output logic          kind_erase,
    output logic          prog_b7,
    output logic [SW-1:0] sect_q,
    output logic          ry_pull_low
);
    localparam int CW = $clog2(SUSP_LAT + 1);
    localparam logic [CW-1:0] WAIT_LAST = CW'(SUSP_LAT - 1);

    est_state_e    state_nx;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nx;

    // next-state selection; a failure outranks a completion
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt_q;
        unique case (state)
            ST_IDLE: begin
                if (op_start) state_nx = op_erase ? ST_ERASE : ST_PROG;
            end
            ST_PROG: begin
                if (op_fail)      state_nx = ST_TOUT;
                else if (op_done) state_nx = ST_IDLE;
            end
            ST_ERASE: begin
                if (op_fail)       state_nx = ST_TOUT;
                else if (op_done)  state_nx = ST_IDLE;
                else if (susp_req) begin
                    state_nx = ST_SWAIT;
                    cnt_nx   = '0;
                end
            end
            ST_SWAIT: begin
                if (op_fail)                 state_nx = ST_TOUT;
                else if (op_done)            state_nx = ST_IDLE;
                else if (cnt_q == WAIT_LAST) state_nx = ST_SUSP;
                else                         cnt_nx   = cnt_q + 1'b1;
            end
            ST_SUSP: begin
                if (resume_req) state_nx = ST_ERASE;
            end
            ST_TOUT: begin
                if (reset_cmd) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state and suspend counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            state <= state_nx;
            cnt_q <= cnt_nx;
        end
    end

    // operation attributes, captured only when a start is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_erase <= 1'b0;
            prog_b7    <= 1'b0;
            sect_q     <= '0;
        end else if (state == ST_IDLE && op_start) begin
            kind_erase <= op_erase;
            prog_b7    <= prog_msb;
            sect_q     <= op_sect;
        end
    end

    // open-drain style busy: pull low whenever work is pending
    always_comb begin
        ry_pull_low = !(state == ST_IDLE || state == ST_SUSP);
    end

    AST_SUSP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWAIT) |-> (cnt_q < CW'(SUSP_LAT))); // R7
    AST_TOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TOUT && !reset_cmd) |=> (state == ST_TOUT)); // R5
    AST_SUSP_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSP) |-> !ry_pull_low); // R6
    AST_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> ($stable(prog_b7) && $stable(kind_erase) && $stable(sect_q))); // R10
endmodule

// File: rtl/est_toggle_bank.sv
// Bank of read-driven toggle flops; each lane inverts when its advance is set
// and otherwise holds. Assumes advances are already qualified by the read path.
module est_toggle_bank #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] adv,
    output logic [N-1:0] tog
);
    for (genvar g = 0; g < N; g++) begin : g_lane
        // one toggle flop per lane
        always_ff @(posedge clk) begin
            if (!rst_n)      tog[g] <= 1'b0;
            else if (adv[g]) tog[g] <= ~tog[g];
        end

        AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
            adv[g] |=> (tog[g] != $past(tog[g]))); // R4
        AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !adv[g] |=> $stable(tog[g])); // R9
    end
endmodule

// File: rtl/est_rdport.sv
// Read port: decides per strobe whether a read returns status or array data,
// builds the status word, registers the result and drives the toggle advances.
// Assumes DW >= 8.
module est_rdport
    import est_pkg::*;
#(
    parameter int DW = 8,
    parameter int SW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  est_state_e       state,
    input  logic             kind_erase,
    input  logic             prog_b7,
    input  logic [SW-1:0]    sect_q,
    input  logic             rd_strobe,
    input  logic [SW-1:0]    rd_sect,
    input  logic [DW-1:0]    arr_data,
    input  logic [LANES-1:0] tog,
    output logic [LANES-1:0] adv,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid
);
    logic          busy_st;
    logic          susp_hit;
    logic          stat_rd;
    logic [DW-1:0] word;

    // classify the current read
    always_comb begin
        busy_st  = (state == ST_PROG) || (state == ST_ERASE) ||
                   (state == ST_SWAIT) || (state == ST_TOUT);
        susp_hit = (state == ST_SUSP) && (rd_sect == sect_q);
        stat_rd  = rd_strobe && (busy_st || susp_hit);
        adv[LANE_PRI] = stat_rd && (state != ST_SUSP);
        adv[LANE_ALT] = stat_rd && kind_erase;
    end

    // assemble the status word
    always_comb begin
        word = '0;
        word[POLL_BIT] = kind_erase ? (state == ST_SUSP) : ~prog_b7;
        word[TOG_BIT]  = tog[LANE_PRI];
        word[TOUT_BIT] = (state == ST_TOUT);
        word[ALT_BIT]  = tog[LANE_ALT];
    end

    // registered read result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_strobe;
            if (rd_strobe) rd_data <= stat_rd ? word : arr_data;
        end
    end

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_strobe)); // R12
    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && state == ST_IDLE) |=> (rd_data == $past(arr_data))); // R1
    AST_TOUT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && state == ST_TOUT) |=> rd_data[TOUT_BIT]); // R5
    AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && state == ST_PROG) |=> (rd_data[POLL_BIT] == !$past(prog_b7))); // R2
endmodule

// File: rtl/emb_status_gen.sv
// Top of the embedded operation status generator: ties the operation tracker,
// the toggle bank and the read port together. Assumes DW >= 8 and that the
// caller supplies the array data for the presented read address.
module emb_status_gen
    import est_pkg::*;
#(
    parameter int DW       = 8,
    parameter int AW       = 12,
    parameter int SECT_LSB = 8,
    parameter int SUSP_LAT = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_start,
    input  logic                 op_erase,
    input  logic                 prog_msb,
    input  logic [AW-SECT_LSB-1:0] op_sect,
    input  logic                 op_done,
    input  logic                 op_fail,
    input  logic                 susp_req,
    input  logic                 resume_req,
    input  logic                 reset_cmd,
    input  logic                 rd_strobe,
    input  logic [AW-SECT_LSB-1:0] rd_sect,
    input  logic [DW-1:0]        arr_data,
    output logic [DW-1:0]        rd_data,
    output logic                 rd_valid,
    output logic                 ry_pull_low
);
    localparam int SW = AW - SECT_LSB;

    est_state_e       state;
    logic             kind_erase;
    logic             prog_b7;
    logic [SW-1:0]    sect_q;
    logic [LANES-1:0] adv;
    logic [LANES-1:0] tog;

    est_seq #(.SW(SW), .SUSP_LAT(SUSP_LAT)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_start   (op_start),
        .op_erase   (op_erase),
        .prog_msb   (prog_msb),
        .op_sect    (op_sect),
        .op_done    (op_done),
        .op_fail    (op_fail),
        .susp_req   (susp_req),
        .resume_req (resume_req),
        .reset_cmd  (reset_cmd),
        .state      (state),
        .kind_erase (kind_erase),
        .prog_b7    (prog_b7),
        .sect_q     (sect_q),
        .ry_pull_low(ry_pull_low)
    );

    est_toggle_bank #(.N(LANES)) u_tog (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (adv),
        .tog  (tog)
    );

    est_rdport #(.DW(DW), .SW(SW)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .kind_erase(kind_erase),
        .prog_b7   (prog_b7),
        .sect_q    (sect_q),
        .rd_strobe (rd_strobe),
        .rd_sect   (rd_sect),
        .arr_data  (arr_data),
        .tog       (tog),
        .adv       (adv),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );
endmodule

// File: tb/emb_status_gen_tb.sv
module emb_status_gen_tb;
    localparam int DW = 8, AW = 12, SL = 8, LAT = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_start = 0, op_erase = 0, prog_msb = 0, op_done = 0, op_fail = 0;
    logic susp_req = 0, resume_req = 0, reset_cmd = 0, rd_strobe = 0;
    logic [3:0]    op_sect = 0;
    logic [AW-1:0] rd_addr = 0;
    logic [DW-1:0] arr_data, rd_data;
    logic rd_valid, ry_pull_low;

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 0;
    logic m6 = 0, m2 = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] arr_f(input logic [AW-1:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'hA5;
    endfunction
    assign arr_data = arr_f(rd_addr);

    emb_status_gen #(.DW(DW), .AW(AW), .SECT_LSB(SL), .SUSP_LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_erase(op_erase),
        .prog_msb(prog_msb), .op_sect(op_sect), .op_done(op_done),
        .op_fail(op_fail), .susp_req(susp_req), .resume_req(resume_req),
        .reset_cmd(reset_cmd), .rd_strobe(rd_strobe), .rd_sect(rd_addr[11:8]),
        .arr_data(arr_data), .rd_data(rd_data), .rd_valid(rd_valid),
        .ry_pull_low(ry_pull_low)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
        end
    end

    task automatic pulse(ref logic s);
        @(negedge clk) s = 1;
        @(negedge clk) s = 0;
    endtask

    task automatic start(input bit er, input bit msb, input logic [3:0] s);
        @(negedge clk) begin op_start = 1; op_erase = er; prog_msb = msb; op_sect = s; end
        @(negedge clk) op_start = 0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [7:0] got, output bit v);
        @(negedge clk) begin rd_strobe = 1; rd_addr = a; end
        @(negedge clk) rd_strobe = 0;
        got = rd_data;
        v = rd_valid;
    endtask

    // status read: expectation built from model toggles, then model advanced
    task automatic rd_stat(input logic [AW-1:0] a, input bit b7, input bit b5,
                           input bit a6, input bit a2, input string tag);
        logic [7:0] exp, got;
        bit v;
        exp = {b7, m6, b5, 2'b00, m2, 2'b00};
        do_read(a, got, v);
        chk(v && got == exp, tag, got, exp);
        m6 ^= a6;
        m2 ^= a2;
    endtask

    task automatic rd_arr(input logic [AW-1:0] a, input string tag);
        logic [7:0] got;
        bit v;
        do_read(a, got, v);
        chk(v && got == arr_f(a), tag, got, arr_f(a));
    endtask

    task automatic chk_ry(input bit exp, input string tag);
        chk(ry_pull_low == exp, tag, {7'd0, ry_pull_low}, {7'd0, exp});
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(rd_valid == 0, "R1 rd_valid", {7'd0, rd_valid}, 8'd0);
        chk(rd_data == 0, "R1 rd_data", rd_data, 8'd0);
        chk_ry(0, "R1 ready");
        rst_n = 1;
        rd_arr(12'h3C7, "R1 idle read");
        @(negedge clk) chk(rd_valid == 0, "R12 valid one cycle", {7'd0, rd_valid}, 8'd0);

        // program sweep over every data value
        for (int d = 0; d < 256; d++) begin
            logic [7:0] dv, got;
            bit v;
            dv = 8'(d);
            start(0, dv[7], 4'(d));
            chk_ry(1, "R6 busy program");
            rd_stat(12'(d * 13), ~dv[7], 0, 1, 0, "R2 poll first");
            repeat (2) @(negedge clk);
            rd_stat(12'(d * 7), ~dv[7], 0, 1, 0, "R4 toggle second");
            start(1, ~dv[7], 4'(d + 1));           // R10 ignored start
            rd_stat(12'(d), ~dv[7], 0, 1, 0, "R10 start ignored");
            pulse(susp_req);                        // R7 ignored in program
            repeat (LAT + 1) @(negedge clk);
            chk_ry(1, "R7 no suspend in program");
            rd_stat(12'(d + 5), ~dv[7], 0, 1, 0, "R9 alt holds in program");
            // R11 completion with a coincident read
            @(negedge clk) begin op_done = 1; rd_strobe = 1; rd_addr = 12'(d * 3); end
            @(negedge clk) begin op_done = 0; rd_strobe = 0; end
            got = rd_data;
            v = rd_valid;
            chk(v && got == {~dv[7], m6, 1'b0, 2'b00, m2, 2'b00}, "R11 read at done",
                got, {~dv[7], m6, 1'b0, 2'b00, m2, 2'b00});
            m6 ^= 1'b1;
            chk_ry(0, "R6 ready after done");
            rd_arr(12'(d * 3), "R11 array after done");
        end

        // erase, completion
        start(1, 0, 4'h3);
        rd_stat(12'h345, 0, 0, 1, 1, "R3 erase poll");
        rd_stat(12'hA00, 0, 0, 1, 1, "R9 alt toggles in erase");
        pulse(op_done);
        chk_ry(0, "R6 ready after erase");
        rd_arr(12'h3FF, "R3 array after erase");
        rd_arr(12'h311, "R4 idle read no toggle");
        start(0, 1, 0);
        rd_stat(12'h001, 0, 0, 1, 0, "R4 toggle held over idle");
        pulse(op_done);

        // timeout from program and from erase
        for (int k = 0; k < 2; k++) begin
            start(k[0], 1, 4'h5);
            pulse(op_fail);
            rd_stat(12'h500, 0, 1, 1, k[0], "R5 timeout bit");
            pulse(op_done);
            chk_ry(1, "R5 busy in timeout");
            rd_stat(12'h123, 0, 1, 1, k[0], "R5 timeout sticky");
            pulse(reset_cmd);
            chk_ry(0, "R5 idle after reset");
            rd_arr(12'h123, "R5 array after reset");
        end

        // suspend over every erase sector and every read sector
        for (int s = 0; s < 16; s++) begin
            start(1, 0, 4'(s));
            rd_stat(12'(s * 256 + 9), 0, 0, 1, 1, "R3 erase before suspend");
            @(negedge clk) susp_req = 1;
            @(negedge clk) susp_req = 0;
            for (int i = 0; i < LAT; i++) begin
                chk_ry(1, "R7 suspend wait busy");
                @(negedge clk);
            end
            chk_ry(0, "R7 suspended at latency");
            for (int r = 0; r < 16; r++) begin
                logic [AW-1:0] a;
                a = {4'(r), 8'(r * 17 + s)};
                if (r == s) rd_stat(a, 1, 0, 0, 1, "R8 suspended sector status");
                else        rd_arr(a, "R8 other sector array");
            end
            pulse(resume_req);
            chk_ry(1, "R8 busy after resume");
            rd_stat(12'h0F0, 0, 0, 1, 1, "R8 erase status after resume");
            pulse(op_done);
            rd_arr(12'(s * 256), "R3 array after resumed erase");
        end

        // completion while waiting to suspend
        start(1, 0, 4'h7);
        pulse(susp_req);
        rd_stat(12'h222, 0, 0, 1, 1, "R3 status during suspend wait");
        pulse(op_done);
        chk_ry(0, "R6 ready after done in wait");
        rd_arr(12'h700, "R3 array after done in wait");

        summary();
    end
endmodule